// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers four interrupt sources and turns them into a single vectored request for a small processor core. Two of the sources are input pins, where a high-to-low transition counts as an event once the pin has been high long enough to be believed. The other two are single-cycle end-of-count pulses from timers. Each event sets a bit in a request register. A per-source enable mask and a global enable bit decide which requests may interrupt, and a selectable ranking picks one when several compete.

For the winning source the block presents the program address of its two-byte vector. The slots are fixed, with reserved gaps between them. When the core accepts the request, the block clears that source's request bit and drops the global enable, so no further request is raised until software turns it back on. A core that prefers polling leaves the sources disabled and reads the request bits directly. They are always visible and are never cleared by masking.

Software reaches the block through a small write port with three registers. Address 0 holds the request bits. Address 1 holds the enables, with bits 3:0 per source and bit 7 as the global enable. Address 2 holds the 3-bit ranking selector.

Top module: `irqc_top`

## Requirements
- R1: A one-cycle pulse on `tmr_done[0]` sets request bit 2, and a pulse on `tmr_done[1]` sets bit 3. The bit is visible on `irq_pend` after the clock edge that samples the pulse.
- R2: On `pin_in[k]`, a fall that follows at least MIN_HIGH (default 3) consecutive high cycles sets request bit k. Bit k shows on `irq_pend` after the third rising clock edge after the pin changes.
- R3: A fall that follows fewer than MIN_HIGH high cycles sets no request bit.
- R4: A request bit stays set until it is acknowledged or overwritten by a write to address 0. Changing the enables does not clear it, and `irq_pend` shows it even while it is masked.
- R5: `irq_valid` is high only when at least one pending source has its enable bit set (bit k of address 1 for source k) and the global enable (bit 7 of address 1) is set.
- R6: The selector at address 2 ranks the sources from first to last as follows: 0 gives 0,1,2,3; 1 gives 1,0,3,2; 2 gives 2,3,0,1; 3 gives 3,2,1,0; 4 gives 0,2,1,3; 5 gives 3,1,2,0. Values 6 and 7 act as 0. `irq_id` is the first enabled pending source in that ranking.
- R7: `irq_vec` is VEC_BASE plus byte offset 2, 4, 8 or 10 for source 0, 1, 2 or 3. Offsets 0 and 6 are never produced.
- R8: `irq_ack` while `irq_valid` is high clears the winning source's request bit and the global enable on the same edge, so `irq_valid` is low in the next cycle. `irq_ack` while `irq_valid` is low has no effect.
- R9: `irq_valid`, `irq_id` and `irq_vec` are registered and reflect the request, enable and selector state produced by the same clock edge.
- R10: After reset, all request bits, the enables and the selector are zero, and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 2 | Asynchronous interrupt pins, events on falling edges |
| tmr_done | input | 2 | One-cycle end-of-count pulses from two timers |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 request, 1 enables, 2 ranking |
| cfg_wdata | input | 8 | Register write data |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_pend | output | 4 | Request register, readable for polling |
| irq_valid | output | 1 | An enabled request is presented |
| irq_id | output | 2 | Source index of the presented request |
| irq_vec | output | VEC_W | Program address of the winner's vector |

## Verification
A register write, a timer pulse and an acknowledge each take effect on one rising edge. Their results are due on `irq_pend` and the presented outputs on that same edge, so the bench drives each stimulus at a falling edge and checks at the next falling edge. Pin events pass two synchroniser stages before they are qualified. The bench therefore checks that the request bit is still clear after two rising edges and set after the third. Priority and masking are swept over every selector value, request pattern and enable pattern, and each expected winner is computed from the ranking table.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 4;
  localparam int NPIN  = 2;
  localparam int NTMR  = NSRC - NPIN;
  localparam int IDW   = $clog2(NSRC);

  typedef logic [IDW-1:0] src_t;

  // Ranking tables, rank 0 in the low two bits (R6)
  function automatic src_t rank_src(input logic [2:0] sel, input int rank);
    logic [7:0] word;
    case (sel)
      3'd1:    word = 8'hB1;
      3'd2:    word = 8'h4E;
      3'd3:    word = 8'h1B;
      3'd4:    word = 8'hD8;
      3'd5:    word = 8'h27;
      default: word = 8'hE4;
    endcase
    return src_t'(word >> (2 * rank));
  endfunction

  // Vector slot (in 16-bit words) for each source; slots 0 and 3 are reserved (R7)
  function automatic int vec_slot(input src_t id);
    case (id)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/irqc_pin_qual.sv
module irqc_pin_qual #(
  parameter int MIN_HIGH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall_evt
);
  localparam int CW = $clog2(MIN_HIGH + 1);

  logic          s1_q, s2_q, prev_q;
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      prev_q   <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (!s2_q)
        hi_cnt_q <= '0;
      else if (hi_cnt_q != CW'(MIN_HIGH))
        hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  // R2/R3: fall counts only after MIN_HIGH qualified high cycles
  assign fall_evt = prev_q && !s2_q && (hi_cnt_q == CW'(MIN_HIGH));
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0] cand,
  input  logic [2:0]      sel,
  output logic            valid,
  output src_t            id
);
  always_comb begin
    valid = 1'b0;
    id    = '0;
    // Walk from the last rank to the first so the first rank wins (R6)
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (cand[rank_src(sel, r)]) begin
        valid = 1'b1;
        id    = rank_src(sel, r);
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 0,
  parameter int MIN_HIGH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       pin_in,
  input  logic [1:0]       tmr_done,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             irq_ack,
  output logic [3:0]       irq_pend,
  output logic             irq_valid,
  output logic [1:0]       irq_id,
  output logic [VEC_W-1:0] irq_vec
);
  localparam logic [1:0] A_REQ = 2'd0;
  localparam logic [1:0] A_EN  = 2'd1;
  localparam logic [1:0] A_PRI = 2'd2;
  localparam int         GIE_BIT = 7;

  logic [NSRC-1:0] req_q, req_n, en_q, en_n, evt;
  logic            gie_q, gie_n, ack_hit, win_v;
  logic [2:0]      pri_q, pri_n;
  src_t            win_id;

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      irqc_pin_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
        .clk(clk), .rst(rst), .pin(pin_in[g]), .fall_evt(evt[g])
      );
    end
    for (g = 0; g < NTMR; g++) begin : g_tmr
      assign evt[NPIN + g] = tmr_done[g];   // R1
    end
  endgenerate

  assign ack_hit = irq_ack && irq_valid;    // R8: ack ignored unless valid

  always_comb begin
    req_n = (cfg_we && cfg_addr == A_REQ) ? cfg_wdata[NSRC-1:0] : req_q;
    en_n  = (cfg_we && cfg_addr == A_EN)  ? cfg_wdata[NSRC-1:0] : en_q;
    gie_n = (cfg_we && cfg_addr == A_EN)  ? cfg_wdata[GIE_BIT]  : gie_q;
    pri_n = (cfg_we && cfg_addr == A_PRI) ? cfg_wdata[2:0]      : pri_q;
    if (ack_hit) begin
      req_n[irq_id] = 1'b0;
      gie_n         = 1'b0;
    end
    req_n = req_n | evt;   // R4: events set, masking never clears
  end

  irqc_pick u_pick (
    .cand(req_n & en_n & {NSRC{gie_n}}),   // R5
    .sel(pri_n),
    .valid(win_v),
    .id(win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin   // R10
      req_q     <= '0;
      en_q      <= '0;
      gie_q     <= 1'b0;
      pri_q     <= '0;
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_vec   <= VEC_W'(VEC_BASE);
    end else begin   // R9: outputs follow next-state on the same edge
      req_q     <= req_n;
      en_q      <= en_n;
      gie_q     <= gie_n;
      pri_q     <= pri_n;
      irq_valid <= win_v;
      irq_id    <= win_id;
      irq_vec   <= VEC_W'(VEC_BASE + 2 * vec_slot(win_id));   // R7
    end
  end

  assign irq_pend = req_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       tmr_done,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic             irq_ack,
  input logic [3:0]       irq_pend,
  input logic             irq_valid,
  input logic [1:0]       irq_id,
  input logic [VEC_W-1:0] irq_vec
);
  logic [VEC_W-1:0] exp_vec;
  always_comb begin
    case (irq_id)
      2'd0:    exp_vec = VEC_W'(VEC_BASE + 2);
      2'd1:    exp_vec = VEC_W'(VEC_BASE + 4);
      2'd2:    exp_vec = VEC_W'(VEC_BASE + 8);
      default: exp_vec = VEC_W'(VEC_BASE + 10);
    endcase
  end

  a_r1_tmr0_sets: assert property (@(posedge clk) disable iff (rst)
    tmr_done[0] |=> irq_pend[2]);
  a_r1_tmr1_sets: assert property (@(posedge clk) disable iff (rst)
    tmr_done[1] |=> irq_pend[3]);
  a_r5_valid_pending: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_pend[irq_id]);
  a_r7_vector_slot: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_vec == exp_vec);
  a_r8_ack_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid) |=> !irq_valid);

  genvar k;
  generate
    for (k = 0; k < 4; k++) begin : g_hold
      a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_pend[k] && !(cfg_we && cfg_addr == 2'd0) &&
         !(irq_ack && irq_valid && irq_id == k)) |=> irq_pend[k]);
    end
  endgenerate
endmodule

bind irqc_top irqc_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .tmr_done(tmr_done), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .irq_ack(irq_ack), .irq_pend(irq_pend),
  .irq_valid(irq_valid), .irq_id(irq_id), .irq_vec(irq_vec)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] pin_in = 2'b11;
  logic [1:0] tmr_done = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic irq_ack = 1'b0;
  logic [3:0] irq_pend;
  logic irq_valid;
  logic [1:0] irq_id;
  logic [VEC_W-1:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ord [0:5][0:3] = '{'{0,1,2,3}, '{1,0,3,2}, '{2,3,0,1},
                         '{3,2,1,0}, '{0,2,1,3}, '{3,1,2,0}};

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.VEC_W(VEC_W)) u_irqc_top (
    .clk(clk), .rst(rst), .pin_in(pin_in), .tmr_done(tmr_done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_ack(irq_ack), .irq_pend(irq_pend), .irq_valid(irq_valid),
    .irq_id(irq_id), .irq_vec(irq_vec)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int winner(input int sel, input int pat);
    int s = (sel > 5) ? 0 : sel;
    for (int r = 0; r < 4; r++)
      if (pat[ord[s][r]]) return ord[s][r];
    return -1;
  endfunction

  function automatic int vec_of(input int id);
    int off [0:3] = '{2, 4, 8, 10};
    return off[id];
  endfunction

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 pend", irq_pend, 0);
    check("R10 valid", irq_valid, 0);

    // R6/R7/R9 exhaustive priority sweep
    wr(1, 8'h8F);
    for (int sel = 0; sel < 8; sel++) begin
      wr(2, sel);
      for (int pat = 1; pat < 16; pat++) begin
        wr(0, pat);
        w = winner(sel, pat);
        check("R9 valid", irq_valid, 1);
        check("R6 id", irq_id, w);
        check("R7 vec", irq_vec, vec_of(w));
      end
    end

    // R5 enable sweep with all requests pending
    wr(2, 0);
    wr(0, 15);
    for (int m = 0; m < 16; m++) begin
      wr(1, 8'h80 | m);
      check("R5 valid", irq_valid, (m != 0) ? 1 : 0);
      if (m != 0) check("R5 id", irq_id, winner(0, m));
    end
    // R4 polled: global off, pending still visible
    wr(1, 8'h0F);
    check("R5 gie off valid", irq_valid, 0);
    check("R4 pend masked", irq_pend, 15);
    wr(1, 8'h00);
    check("R4 pend kept", irq_pend, 15);

    // R8 ack without valid ignored
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R8 ack ignored", irq_pend, 15);

    // R8 ack clears winner and global enable
    wr(1, 8'h8F);
    check("R8 pre id", irq_id, 0);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R8 bit cleared", irq_pend, 14);
    check("R8 valid dropped", irq_valid, 0);
    wr(1, 8'h8F);
    check("R8 reenabled id", irq_id, 1);
    wr(0, 0);
    check("R4 sw clear", irq_pend, 0);

    // R1 timer pulses
    tmr_done = 2'b01; @(negedge clk); tmr_done = 2'b00;
    check("R1 tmr0", irq_pend, 4);
    check("R9 tmr valid", irq_valid, 1);
    check("R7 tmr vec", irq_vec, 8);
    tmr_done = 2'b10; @(negedge clk); tmr_done = 2'b00;
    check("R1 tmr1", irq_pend, 12);
    wr(0, 0);

    // R2 pin latency: pins have been high since reset
    pin_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 pin0 early", irq_pend, 0);
    @(negedge clk);
    check("R2 pin0 set", irq_pend, 1);
    pin_in[1] = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 pin1 set", irq_pend, 3);
    wr(0, 0);

    // R3 short high pulse ignored, MIN_HIGH accepted
    repeat (4) @(negedge clk);
    pin_in[0] = 1'b1; repeat (2) @(negedge clk); pin_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 short ignored", irq_pend, 0);
    pin_in[0] = 1'b1; repeat (3) @(negedge clk); pin_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 min high accepted", irq_pend, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule